// File: doc/BRIEF.md
# Core Wrapper Instruction Path Controller

This block sits beside the instruction register of a core test wrapper and turns its active instruction into the wrapper's datapath configuration. When an instruction scan ends with an update, the parallel opcode from the instruction shifter is decoded and stored. The stored mode then picks which data register lies between the wrapper serial input and serial output: a one-bit bypass, the boundary register alone, or the boundary register followed by the core's internal scan chain.

The same mode picks the source of every functional output. The choices are the live core value, the update stage of the boundary register, or a safe constant fixed when the block is instantiated. The mode also sets the core quiet request and the inward-facing flag of the boundary register. Opcode values are parameters. An unrecognised code behaves like normal functional mode. The boundary register here has one cell per functional output. It has a shift stage that captures the core outputs and an update stage that feeds the outputs.

Top module: `wrapper_path_ctrl`

## Requirements
- R1: After synchronous reset the mode is normal: bypass path, `func_out` equals `core_out`, `core_quiet` and `wbr_inward` low, both boundary stages and the bypass bit cleared.
- R2: The active mode changes only at a clock edge where `sel_ir` and `update_en` are both high, and it then takes `ir_in`. The default codes are normal 0, external test 1, preload 2, clamp 3, safe 4, ring internal test 5, and scan internal test 6.
- R3: Any code that matches no opcode parameter (7 by default) acts exactly like normal mode.
- R4: In safe mode the bypass bit is the serial path, so `wso` shows the `wsi` value from the last shift. `func_out` equals `SAFE_VAL` (default 8'hA5).
- R5: In clamp mode the bypass bit is the serial path. `func_out` equals the boundary update stage and stays unchanged for as long as clamp stays active, whatever the shift, capture, update or `core_out` activity.
- R6: In preload mode only the boundary register is in the path. A shift enters `wsi` at bit N-1 and moves every bit one place down, and `wso` shows bit 0. `func_out` keeps following `core_out`.
- R7: In external test mode the boundary register is the path and `func_out` equals the update stage. Preloaded values appear on the first cycle after the instruction update.
- R8: In ring internal test mode only the boundary register is in the path, `wbr_inward` is high, and `func_out` equals `SAFE_VAL`.
- R9: In scan internal test mode boundary bit 0 drives `chain_si`, `chain_so` drives `wso`, and `chain_shift` follows `shift_en`. `wbr_inward` is high and `func_out` equals `SAFE_VAL`. `chain_shift` is low in every other mode.
- R10: `core_quiet` is high in the safe, clamp, preload, ring and scan modes. It is low in normal mode, external test mode and unknown-code mode.
- R11: In a mode that uses the boundary register, capture loads `core_out` into the shift stage and update copies the shift stage into the update stage. Capture takes priority over shift, and shift over update. In a bypass mode, capture clears the bypass bit and update leaves the boundary register unchanged.
- R12: While `sel_ir` is high, `wso` equals `ir_so` and no data register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| wsi | input | 1 | Wrapper serial input |
| shift_en | input | 1 | Shift strobe |
| capture_en | input | 1 | Capture strobe |
| update_en | input | 1 | Update strobe |
| sel_ir | input | 1 | Instruction register selected for scan |
| ir_in | input | IR_W | Parallel opcode from instruction shifter |
| ir_so | input | 1 | Serial output of instruction shifter |
| core_out | input | N_FO | Functional values from the core |
| chain_so | input | 1 | Internal scan chain output |
| wso | output | 1 | Wrapper serial output |
| func_out | output | N_FO | Wrapper functional outputs |
| chain_si | output | 1 | Internal scan chain input |
| chain_shift | output | 1 | Internal scan chain shift enable |
| core_quiet | output | 1 | Request to hold the core in a quiet state |
| wbr_inward | output | 1 | Boundary register in inward-facing mode |

## Verification
The hardest situation to reach is clamp mode holding a specific non-reset pattern. It needs a preload, a full shift of the boundary register, an update, and then a second instruction scan before the hold can be seen. The stimulus follows that sequence. While clamp is active it then changes `core_out`, shifts the bypass and pulses capture and update. Ring and scan modes are reached the same way, through instruction updates, and there the captured core values are shifted back out.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        M_NORMAL, M_EXTEST, M_PRELOAD, M_CLAMP, M_SAFE, M_RING, M_SCAN
    } mode_e;

    typedef enum logic [1:0] {P_BYPASS, P_BOUND, P_CHAIN} path_e;

    typedef enum logic [1:0] {F_CORE, F_UPD, F_SAFE} fo_e;

    typedef struct packed {
        path_e path;
        fo_e   fo;
        logic  quiet;
        logic  inward;
    } cfg_t;

    function automatic cfg_t cfg_of(mode_e m);
        cfg_t c;
        c = '{path: P_BYPASS, fo: F_CORE, quiet: 1'b0, inward: 1'b0};
        case (m)
            M_EXTEST:  begin c.path = P_BOUND;  c.fo = F_UPD;  end
            M_PRELOAD: begin c.path = P_BOUND;  c.fo = F_CORE; c.quiet = 1'b1; end
            M_CLAMP:   begin c.path = P_BYPASS; c.fo = F_UPD;  c.quiet = 1'b1; end
            M_SAFE:    begin c.path = P_BYPASS; c.fo = F_SAFE; c.quiet = 1'b1; end
            M_RING:    begin c.path = P_BOUND;  c.fo = F_SAFE; c.quiet = 1'b1; c.inward = 1'b1; end
            M_SCAN:    begin c.path = P_CHAIN;  c.fo = F_SAFE; c.quiet = 1'b1; c.inward = 1'b1; end
            default:   c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wpc_decode.sv
module wpc_decode
    import wpc_pkg::*;
#(
    parameter int IR_W = 3,
    parameter logic [IR_W-1:0] OP_NORMAL  = 3'd0,
    parameter logic [IR_W-1:0] OP_EXTEST  = 3'd1,
    parameter logic [IR_W-1:0] OP_PRELOAD = 3'd2,
    parameter logic [IR_W-1:0] OP_CLAMP   = 3'd3,
    parameter logic [IR_W-1:0] OP_SAFE    = 3'd4,
    parameter logic [IR_W-1:0] OP_RING    = 3'd5,
    parameter logic [IR_W-1:0] OP_SCAN    = 3'd6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [IR_W-1:0] code,
    output mode_e           mode
);

    mode_e next_mode;

    always_comb begin
        if      (code == OP_EXTEST)  next_mode = M_EXTEST;
        else if (code == OP_PRELOAD) next_mode = M_PRELOAD;
        else if (code == OP_CLAMP)   next_mode = M_CLAMP;
        else if (code == OP_SAFE)    next_mode = M_SAFE;
        else if (code == OP_RING)    next_mode = M_RING;
        else if (code == OP_SCAN)    next_mode = M_SCAN;
        else                         next_mode = M_NORMAL; // OP_NORMAL and unknown codes
    end

    always_ff @(posedge clk) begin
        if (rst)       mode <= M_NORMAL;
        else if (load) mode <= next_mode;
    end

    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mode));

endmodule

// File: rtl/wpc_bypass.sv
module wpc_bypass (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic capture,
    input  logic shift,
    input  logic si,
    output logic so
);

    logic bit_q;

    always_ff @(posedge clk) begin
        if (rst)               bit_q <= 1'b0;
        else if (en && capture) bit_q <= 1'b0;
        else if (en && shift)   bit_q <= si;
    end

    assign so = bit_q;

    a_r11_bypass_capture_zero: assert property (@(posedge clk) disable iff (rst)
        (en && capture) |=> !so);

endmodule

// File: rtl/wpc_bound.sv
module wpc_bound #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         capture,
    input  logic         shift,
    input  logic         update,
    input  logic         si,
    input  logic [N-1:0] par_in,
    output logic [N-1:0] upd_q,
    output logic         so
);

    logic [N-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            upd_q <= '0;
        end else if (en) begin
            if (capture)     sh_q  <= par_in;
            else if (shift)  sh_q  <= {si, sh_q[N-1:1]};
            else if (update) upd_q <= sh_q;
        end
    end

    assign so = sh_q[0];

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sh_q) && $stable(upd_q)));

    a_r11_update_copy: assert property (@(posedge clk) disable iff (rst)
        (en && update && !capture && !shift) |=> (upd_q == $past(sh_q)));

endmodule

// File: rtl/wrapper_path_ctrl.sv
module wrapper_path_ctrl
    import wpc_pkg::*;
#(
    parameter int IR_W = 3,
    parameter int N_FO = 8,
    parameter logic [N_FO-1:0] SAFE_VAL = 8'hA5,
    parameter logic [IR_W-1:0] OP_NORMAL  = 3'd0,
    parameter logic [IR_W-1:0] OP_EXTEST  = 3'd1,
    parameter logic [IR_W-1:0] OP_PRELOAD = 3'd2,
    parameter logic [IR_W-1:0] OP_CLAMP   = 3'd3,
    parameter logic [IR_W-1:0] OP_SAFE    = 3'd4,
    parameter logic [IR_W-1:0] OP_RING    = 3'd5,
    parameter logic [IR_W-1:0] OP_SCAN    = 3'd6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wsi,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            update_en,
    input  logic            sel_ir,
    input  logic [IR_W-1:0] ir_in,
    input  logic            ir_so,
    input  logic [N_FO-1:0] core_out,
    input  logic            chain_so,
    output logic            wso,
    output logic [N_FO-1:0] func_out,
    output logic            chain_si,
    output logic            chain_shift,
    output logic            core_quiet,
    output logic            wbr_inward
);

    mode_e           mode;
    cfg_t            cfg;
    logic            dr_sel;
    logic            bound_en;
    logic            byp_en;
    logic            bound_so;
    logic            byp_so;
    logic [N_FO-1:0] upd_q;

    wpc_decode #(
        .IR_W(IR_W), .OP_NORMAL(OP_NORMAL), .OP_EXTEST(OP_EXTEST),
        .OP_PRELOAD(OP_PRELOAD), .OP_CLAMP(OP_CLAMP), .OP_SAFE(OP_SAFE),
        .OP_RING(OP_RING), .OP_SCAN(OP_SCAN)
    ) u_decode (
        .clk  (clk),
        .rst  (rst),
        .load (sel_ir && update_en),
        .code (ir_in),
        .mode (mode)
    );

    assign cfg      = cfg_of(mode);
    assign dr_sel   = !sel_ir;
    assign bound_en = dr_sel && (cfg.path != P_BYPASS);
    assign byp_en   = dr_sel && (cfg.path == P_BYPASS);

    wpc_bypass u_bypass (
        .clk     (clk),
        .rst     (rst),
        .en      (byp_en),
        .capture (capture_en),
        .shift   (shift_en),
        .si      (wsi),
        .so      (byp_so)
    );

    wpc_bound #(.N(N_FO)) u_bound (
        .clk     (clk),
        .rst     (rst),
        .en      (bound_en),
        .capture (capture_en),
        .shift   (shift_en),
        .update  (update_en),
        .si      (wsi),
        .par_in  (core_out),
        .upd_q   (upd_q),
        .so      (bound_so)
    );

    always_comb begin
        if (sel_ir) wso = ir_so;
        else begin
            case (cfg.path)
                P_BOUND: wso = bound_so;
                P_CHAIN: wso = chain_so;
                default: wso = byp_so;
            endcase
        end
    end

    always_comb begin
        case (cfg.fo)
            F_UPD:   func_out = upd_q;
            F_SAFE:  func_out = SAFE_VAL;
            default: func_out = core_out;
        endcase
    end

    assign chain_si    = bound_so;
    assign chain_shift = dr_sel && shift_en && (cfg.path == P_CHAIN);
    assign core_quiet  = cfg.quiet;
    assign wbr_inward  = cfg.inward;

    a_r5_clamp_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == M_CLAMP && !(sel_ir && update_en)) |=> $stable(func_out));

    a_r9_chain_needs_inward: assert property (@(posedge clk) disable iff (rst)
        chain_shift |-> wbr_inward);

    a_r4_safe_const: assert property (@(posedge clk) disable iff (rst)
        (mode == M_SAFE) |-> (func_out == SAFE_VAL));

    a_r6_preload_passthru: assert property (@(posedge clk) disable iff (rst)
        (mode == M_PRELOAD) |-> (func_out == core_out));

    always_comb begin
        if (!rst) a_r10_quiet_excl: assert (!(core_quiet && mode == M_EXTEST));
    end

endmodule

// File: tb/test_wrapper_path_ctrl.sv
module test_wrapper_path_ctrl;

    localparam int   N   = 8;
    localparam logic [N-1:0] SAFE = 8'hA5;

    logic         clk = 1'b0;
    logic         rst;
    logic         wsi, shift_en, capture_en, update_en, sel_ir, ir_so, chain_so;
    logic [2:0]   ir_in;
    logic [N-1:0] core_out;
    logic         wso, chain_si, chain_shift, core_quiet, wbr_inward;
    logic [N-1:0] func_out;

    int n_run = 0;
    int n_fail = 0;

    logic [N-1:0] m_sh, m_up;
    logic         m_byp;
    logic [2:0]   m_op;

    always #10 clk = ~clk;

    wrapper_path_ctrl i_wrapper_path_ctrl (
        .clk(clk), .rst(rst), .wsi(wsi), .shift_en(shift_en), .capture_en(capture_en),
        .update_en(update_en), .sel_ir(sel_ir), .ir_in(ir_in), .ir_so(ir_so),
        .core_out(core_out), .chain_so(chain_so), .wso(wso), .func_out(func_out),
        .chain_si(chain_si), .chain_shift(chain_shift), .core_quiet(core_quiet),
        .wbr_inward(wbr_inward)
    );

    // 0 normal, 1 extest, 2 preload, 3 clamp, 4 safe, 5 ring, 6 scan; others normal (R3)
    function automatic int kind(logic [2:0] op);
        return (op <= 3'd6) ? int'(op) : 0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        int k;
        if (rst) begin
            m_sh = '0; m_up = '0; m_byp = 1'b0; m_op = 3'd0;
        end else if (sel_ir) begin
            if (update_en) m_op = ir_in;
        end else begin
            k = kind(m_op);
            if (k == 1 || k == 2 || k == 5 || k == 6) begin
                if (capture_en)     m_sh = core_out;
                else if (shift_en)  m_sh = {wsi, m_sh[N-1:1]};
                else if (update_en) m_up = m_sh;
            end else begin
                if (capture_en)     m_byp = 1'b0;
                else if (shift_en)  m_byp = wsi;
            end
        end
    endtask

    task automatic compare();
        int k;
        logic e_wso;
        logic [N-1:0] e_fo;
        k = kind(m_op);
        if (sel_ir)                          e_wso = ir_so;
        else if (k == 0 || k == 3 || k == 4) e_wso = m_byp;
        else if (k == 6)                     e_wso = chain_so;
        else                                 e_wso = m_sh[0];
        if (k == 0 || k == 2)      e_fo = core_out;
        else if (k == 1 || k == 3) e_fo = m_up;
        else                       e_fo = SAFE;
        chk("R12/R6 serial path wso", wso, e_wso);
        chk("R4/R5/R7 func_out", func_out, e_fo);
        chk("R10 core_quiet", core_quiet, (k >= 2) ? 1 : 0);
        chk("R8/R9 wbr_inward", wbr_inward, (k == 5 || k == 6) ? 1 : 0);
        chk("R9 chain_shift", chain_shift, (k == 6 && shift_en && !sel_ir) ? 1 : 0);
        if (k == 6) chk("R9 chain_si", chain_si, m_sh[0]);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        shift_en = 0; capture_en = 0; update_en = 0; sel_ir = 0;
    endtask

    task automatic load_ir(logic [2:0] op);
        idle();
        sel_ir = 1; ir_in = op; update_en = 1; ir_so = ~ir_so;
        step();
        idle();
    endtask

    task automatic shift_word(logic [N-1:0] pat);
        idle();
        shift_en = 1;
        for (int i = 0; i < N; i++) begin
            wsi = pat[i];
            step();
        end
        idle();
    endtask

    task automatic pulse_update();
        idle(); update_en = 1; step(); idle();
    endtask

    task automatic pulse_capture();
        idle(); capture_en = 1; step(); idle();
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1; wsi = 0; ir_so = 0; chain_so = 0; ir_in = 0; core_out = 8'h5A;
        idle();
        @(negedge clk);
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 func_out after reset", func_out, 8'h5A);
        chk("R1 quiet after reset", core_quiet, 0);
        chk("R1 bypass after reset", wso, 0);

        // normal mode bypass shifting
        shift_en = 1;
        for (int i = 0; i < 6; i++) begin wsi = i[0]; core_out = 8'(i * 37); step(); end
        idle();

        // R2: staged code without update has no effect
        sel_ir = 1; ir_in = 3'd4; ir_so = 1;
        step();
        chk("R12 wso follows ir_so", wso, 1);
        sel_ir = 0; step();
        chk("R2 no update keeps normal", func_out, core_out);

        // R6 preload: shift 3C, outputs keep following core
        load_ir(3'd2);
        shift_en = 1;
        for (int i = 0; i < N; i++) begin
            wsi = 1'((8'h3C >> i) & 1); core_out = 8'(8'hF0 ^ i); step();
            chk("R6 preload passthru", func_out, core_out);
        end
        idle();
        pulse_update();
        chk("R6 preload output still core", func_out, core_out);

        // R7 extest shows preloaded value right after instruction update
        load_ir(3'd1);
        chk("R7 extest drives preload", func_out, 8'h3C);

        // R11 capture then shift out through wso
        core_out = 8'h96;
        pulse_capture();
        chk("R11 capture bit0 on wso", wso, 0);
        shift_word(8'h41);
        pulse_update();
        chk("R11 update copies shift stage", func_out, 8'h41);

        // R5 clamp holds
        load_ir(3'd3);
        core_out = 8'h00;
        shift_word(8'hFF);
        pulse_capture();
        pulse_update();
        chk("R5 clamp holds value", func_out, 8'h41);
        chk("R10 clamp quiet", core_quiet, 1);

        // R4 safe
        load_ir(3'd4);
        chk("R4 safe constant", func_out, SAFE);
        shift_en = 1; wsi = 1; step();
        chk("R4 bypass delay", wso, 1);
        wsi = 0; step(); idle();

        // R8 ring
        load_ir(3'd5);
        core_out = 8'hC3;
        pulse_capture();
        chk("R8 ring inward", wbr_inward, 1);
        chk("R8 ring safe outputs", func_out, SAFE);
        shift_word(8'h0F);

        // R9 scan
        load_ir(3'd6);
        shift_en = 1;
        for (int i = 0; i < 10; i++) begin wsi = i[1]; chain_so = i[0]; step(); end
        idle();
        chk("R9 chain_so reaches wso", wso, chain_so);

        // R3 unknown code
        load_ir(3'd7);
        core_out = 8'h77;
        step();
        chk("R3 unknown passthru", func_out, 8'h77);
        chk("R3 unknown not quiet", core_quiet, 0);

        // back to extest: update stage kept across modes
        load_ir(3'd1);
        chk("R7 extest keeps last update", func_out, 8'h41);

        // reset again
        rst = 1; step(); rst = 0; step();
        chk("R1 reset returns normal", func_out, 8'h77);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule